// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block turns a free-running reference clock into a signed frequency-offset code that traces a triangular spread-spectrum profile. A downstream current-steering DAC or fractional feedback divider consumes the code to sweep a PLL's output frequency slightly. The sweep spreads the energy of the clock's spectral lines and so lowers the peak emission.

Two selects fix the shape. The range select sets how many reference clocks make up one modulation period. The rate select picks the spread type and the depth. Center spread swings evenly above and below zero. Down spread stays at or below zero. The period length is not constant. Successive periods cycle through a short, a nominal, a long and a nominal count, so the long-run mean is the nominal count and the modulation tone itself is smeared.

The enable input and the active-low power-down input both park the output at zero offset. Any change of the range or rate select restarts the profile from zero.

Top module: `ssc_profile_gen`

## Requirements
- R1: Period length in reference clocks per range select: 00 gives 1920/2280/2640, 10 gives 3200/3800/4400, 11 gives 3840/4560/5280, 01 gives 6400/7600/8800 (short/nominal/long).
- R2: After each start, successive periods take the short, nominal, long and nominal counts in that order, then repeat. The mean over each group of four equals the nominal count.
- R3: Within a period the offset moves linearly. It changes by at most one code per clock, and after k clocks of a segment of a period of P clocks it equals the segment start plus or minus floor(k·S/(P/2)), where S is the peak-to-peak span.
- R4: Center spread: rate 10 swings ±50 and rate 11 swings ±150, in signed 12-bit codes of 0.01 %. The profile starts at 0 and rises for P/4 clocks, falls for P/2 clocks, then rises for P/4 clocks.
- R5: Down spread: rate 00 spans 0 to −100 and rate 01 spans 0 to −300. The offset is never positive. It falls from 0 for P/2 clocks, then rises back for P/2 clocks.
- R6: While the enable input is low, the offset is 0, the valid flag is low and no strobe is produced.
- R7: While power-down is low, the offset is 0 and the valid flag is low. When power-down returns high, the profile restarts from the beginning of a period.
- R8: A one-clock strobe marks the end of every period. In that clock the offset is 0 and a new period begins.
- R9: A change of the range or rate select while running restarts the profile: the offset is 0 on the clock after the change, and the period sequence restarts at the short count.
- R10: During reset the offset is 0 and the valid and strobe outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| range_sel_i | input | 2 | Period range select (see R1) |
| mode_sel_i | input | 2 | Spread type and depth: 00 −1.0 % down, 01 −3.0 % down, 10 0.5 % center, 11 1.5 % center |
| mod_en_i | input | 1 | Modulation enable; low holds the offset at zero |
| pd_ni | input | 1 | Power-down, active low |
| offset_o | output | 12 | Signed offset code, 0.01 % per LSB |
| valid_o | output | 1 | High while the profile is running |
| period_stb_o | output | 1 | One-clock pulse at each period end |

## Verification
The checker watches several properties on every clock. It confirms that the offset is zero whenever the profile is idle, in power-down or at a strobe, and that the offset never moves more than one code between clocks of a steady run. It checks the bounds for each spread type and depth, and that every completed period has one of the three lengths allowed for the selected range. The bench alone can show the exact sample-by-sample triangle values, the short–nominal–long–nominal order with its mean, that the full peaks are reached, and where the profile resumes after enable, power-down or a select change. It compares every output on every clock against a model built from the requirements.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic [1:0] {
    SEQ_MIN   = 2'd0,
    SEQ_NOM_A = 2'd1,
    SEQ_MAX   = 2'd2,
    SEQ_NOM_B = 2'd3
  } seq_e;

  typedef struct packed {
    logic [1:0] range;
    logic [1:0] mode;
  } cfg_t;
endpackage

// File: rtl/ssc_period_sel.sv
module ssc_period_sel import ssc_pkg::*; #(
  parameter int unsigned UNIT_R00 = 120,
  parameter int unsigned UNIT_R01 = 400,
  parameter int unsigned UNIT_R10 = 200,
  parameter int unsigned UNIT_R11 = 240,
  parameter int unsigned MUL_MIN  = 16,
  parameter int unsigned MUL_NOM  = 19,
  parameter int unsigned MUL_MAX  = 22,
  parameter int unsigned CNT_W    = 14
) (
  input  logic [1:0]       range_i,
  input  seq_e             seq_i,
  output logic [CNT_W-1:0] period_o
);
  int unsigned unit, mul;

  always_comb begin
    unique case (range_i)
      2'b00:   unit = UNIT_R00;
      2'b01:   unit = UNIT_R01;
      2'b10:   unit = UNIT_R10;
      default: unit = UNIT_R11;
    endcase
    unique case (seq_i)
      SEQ_MIN: mul = MUL_MIN;
      SEQ_MAX: mul = MUL_MAX;
      default: mul = MUL_NOM;
    endcase
    period_o = CNT_W'(unit * mul);
  end
endmodule

// File: rtl/ssc_depth_sel.sv
module ssc_depth_sel #(
  parameter int unsigned DEPTH_D0 = 100,
  parameter int unsigned DEPTH_D1 = 300,
  parameter int unsigned DEPTH_C0 = 50,
  parameter int unsigned DEPTH_C1 = 150,
  parameter int unsigned OFS_W    = 12
) (
  input  logic [1:0]       mode_i,
  output logic [OFS_W-1:0] span_o,
  output logic             center_o
);
  int unsigned depth;

  always_comb begin
    unique case (mode_i)
      2'b00:   depth = DEPTH_D0;
      2'b01:   depth = DEPTH_D1;
      2'b10:   depth = DEPTH_C0;
      default: depth = DEPTH_C1;
    endcase
    center_o = mode_i[1];
    // span is peak-to-peak: center swings both ways
    span_o   = OFS_W'(mode_i[1] ? 2 * depth : depth);
  end
endmodule

// File: rtl/ssc_tri_core.sv
module ssc_tri_core import ssc_pkg::*; #(
  parameter int unsigned CNT_W = 14,
  parameter int unsigned OFS_W = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic [CNT_W-1:0]        period_i,
  input  logic [OFS_W-1:0]        span_i,
  input  logic                    center_i,
  output seq_e                    seq_o,
  output logic signed [OFS_W-1:0] level_o,
  output logic                    wrap_o
);
  localparam int unsigned ACC_W = CNT_W + 1;
  localparam logic signed [OFS_W-1:0] LVL_ONE = OFS_W'(1);

  logic [CNT_W-1:0]        t_q, half, quarter;
  logic [ACC_W-1:0]        acc_q, acc_sum, acc_nxt;
  logic signed [OFS_W-1:0] lvl_q;
  logic                    wrap_q, up, step, last;
  seq_e                    seq_q;

  always_comb begin
    half    = period_i >> 1;
    quarter = period_i >> 2;
    // center: up, down, up over 1/4, 1/2, 1/4; down spread: down then up
    up      = center_i ? ((t_q < quarter) || (t_q >= half + quarter)) : (t_q >= half);
    acc_sum = acc_q + ACC_W'(span_i);
    step    = acc_sum >= ACC_W'(half);
    acc_nxt = step ? acc_sum - ACC_W'(half) : acc_sum;
    last    = (t_q == period_i - CNT_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q    <= '0;
      acc_q  <= '0;
      lvl_q  <= '0;
      wrap_q <= 1'b0;
      seq_q  <= SEQ_MIN;
    end else if (clear_i) begin
      t_q    <= '0;
      acc_q  <= '0;
      lvl_q  <= '0;
      wrap_q <= 1'b0;
      seq_q  <= SEQ_MIN;
    end else begin
      wrap_q <= last;
      acc_q  <= acc_nxt;
      if (step) lvl_q <= up ? lvl_q + LVL_ONE : lvl_q - LVL_ONE;
      if (last) begin
        t_q   <= '0;
        seq_q <= seq_e'(seq_q + 2'd1);
      end else begin
        t_q   <= t_q + CNT_W'(1);
      end
    end
  end

  assign seq_o   = seq_q;
  assign level_o = lvl_q;
  assign wrap_o  = wrap_q;
endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen import ssc_pkg::*; #(
  parameter int unsigned UNIT_R00 = 120,
  parameter int unsigned UNIT_R01 = 400,
  parameter int unsigned UNIT_R10 = 200,
  parameter int unsigned UNIT_R11 = 240,
  parameter int unsigned MUL_MIN  = 16,
  parameter int unsigned MUL_NOM  = 19,
  parameter int unsigned MUL_MAX  = 22,
  parameter int unsigned DEPTH_D0 = 100,
  parameter int unsigned DEPTH_D1 = 300,
  parameter int unsigned DEPTH_C0 = 50,
  parameter int unsigned DEPTH_C1 = 150,
  parameter int unsigned OFS_W    = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              range_sel_i,
  input  logic [1:0]              mode_sel_i,
  input  logic                    mod_en_i,
  input  logic                    pd_ni,
  output logic signed [OFS_W-1:0] offset_o,
  output logic                    valid_o,
  output logic                    period_stb_o
);
  localparam int unsigned UNIT_A   = (UNIT_R00 > UNIT_R01) ? UNIT_R00 : UNIT_R01;
  localparam int unsigned UNIT_B   = (UNIT_R10 > UNIT_R11) ? UNIT_R10 : UNIT_R11;
  localparam int unsigned UNIT_MAX = (UNIT_A > UNIT_B) ? UNIT_A : UNIT_B;
  localparam int unsigned PER_MAX  = UNIT_MAX * MUL_MAX;
  localparam int unsigned CNT_W    = $clog2(PER_MAX + 1);

  cfg_t             cfg_now, cfg_q;
  logic             run, clear, valid_q;
  seq_e             seq;
  logic [CNT_W-1:0] period;
  logic [OFS_W-1:0] span;
  logic             center;

  assign cfg_now = '{range: range_sel_i, mode: mode_sel_i};
  assign run     = pd_ni && mod_en_i;
  assign clear   = !run || (cfg_now != cfg_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_now;
      valid_q <= run;
    end
  end

  ssc_period_sel #(
    .UNIT_R00(UNIT_R00), .UNIT_R01(UNIT_R01), .UNIT_R10(UNIT_R10), .UNIT_R11(UNIT_R11),
    .MUL_MIN(MUL_MIN), .MUL_NOM(MUL_NOM), .MUL_MAX(MUL_MAX), .CNT_W(CNT_W)
  ) u_period (
    .range_i (range_sel_i),
    .seq_i   (seq),
    .period_o(period)
  );

  ssc_depth_sel #(
    .DEPTH_D0(DEPTH_D0), .DEPTH_D1(DEPTH_D1), .DEPTH_C0(DEPTH_C0), .DEPTH_C1(DEPTH_C1),
    .OFS_W(OFS_W)
  ) u_depth (
    .mode_i  (mode_sel_i),
    .span_o  (span),
    .center_o(center)
  );

  ssc_tri_core #(.CNT_W(CNT_W), .OFS_W(OFS_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .period_i(period),
    .span_i  (span),
    .center_i(center),
    .seq_o   (seq),
    .level_o (offset_o),
    .wrap_o  (period_stb_o)
  );

  assign valid_o = valid_q;
endmodule

// File: rtl/ssc_profile_chk.sv
module ssc_profile_chk #(
  parameter int unsigned UNIT_R00 = 120,
  parameter int unsigned UNIT_R01 = 400,
  parameter int unsigned UNIT_R10 = 200,
  parameter int unsigned UNIT_R11 = 240,
  parameter int unsigned MUL_MIN  = 16,
  parameter int unsigned MUL_NOM  = 19,
  parameter int unsigned MUL_MAX  = 22,
  parameter int unsigned DEPTH_D0 = 100,
  parameter int unsigned DEPTH_D1 = 300,
  parameter int unsigned DEPTH_C0 = 50,
  parameter int unsigned DEPTH_C1 = 150,
  parameter int unsigned OFS_W    = 12
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [1:0]              range_sel_i,
  input logic [1:0]              mode_sel_i,
  input logic                    mod_en_i,
  input logic                    pd_ni,
  input logic signed [OFS_W-1:0] offset_o,
  input logic                    valid_o,
  input logic                    period_stb_o
);
  logic [3:0] cfg1, cfg2;
  int         run_cnt, ofs, unit;

  assign ofs = int'(offset_o);

  always_comb begin
    unique case (cfg1[3:2])
      2'b00:   unit = int'(UNIT_R00);
      2'b01:   unit = int'(UNIT_R01);
      2'b10:   unit = int'(UNIT_R10);
      default: unit = int'(UNIT_R11);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg1    <= '0;
      cfg2    <= '0;
      run_cnt <= 0;
    end else begin
      cfg1 <= {range_sel_i, mode_sel_i};
      cfg2 <= cfg1;
      if (!pd_ni || !mod_en_i || ({range_sel_i, mode_sel_i} != cfg1)) run_cnt <= 0;
      else if (period_stb_o) run_cnt <= 1;
      else run_cnt <= run_cnt + 1;
    end
  end

  AST_PERIOD_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_stb_o |-> (run_cnt == unit * int'(MUL_MIN) || run_cnt == unit * int'(MUL_NOM) ||
                      run_cnt == unit * int'(MUL_MAX))); // R1

  AST_SLOPE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o) && cfg1 == cfg2) |->
      ((ofs - $past(ofs) <= 1) && (ofs - $past(ofs) >= -1))); // R3

  AST_CENTER_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cfg1[1]) |->
      ((ofs <= int'(cfg1[0] ? DEPTH_C1 : DEPTH_C0)) && (ofs >= -int'(cfg1[0] ? DEPTH_C1 : DEPTH_C0)))); // R4

  AST_DOWN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !cfg1[1]) |-> ((ofs <= 0) && (ofs >= -int'(cfg1[0] ? DEPTH_D1 : DEPTH_D0)))); // R5

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (ofs == 0 && !period_stb_o)); // R6

  AST_PD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!pd_ni) |-> (ofs == 0 && !valid_o)); // R7

  AST_STB_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_stb_o |-> (ofs == 0 && valid_o)); // R8

  AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg1 != cfg2) |-> (ofs == 0 && !period_stb_o)); // R9

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_IDLE: assert (ofs == 0 && !valid_o && !period_stb_o); // R10
    end
  end
endmodule

bind ssc_profile_gen ssc_profile_chk #(
  .UNIT_R00(UNIT_R00), .UNIT_R01(UNIT_R01), .UNIT_R10(UNIT_R10), .UNIT_R11(UNIT_R11),
  .MUL_MIN(MUL_MIN), .MUL_NOM(MUL_NOM), .MUL_MAX(MUL_MAX),
  .DEPTH_D0(DEPTH_D0), .DEPTH_D1(DEPTH_D1), .DEPTH_C0(DEPTH_C0), .DEPTH_C1(DEPTH_C1),
  .OFS_W(OFS_W)
) u_chk (.*);

// File: tb/sim_ssc_profile_gen.sv
module sim_ssc_profile_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] rng = 2'd0, mode = 2'd0;
  logic en = 1'b0, pd = 1'b1;
  logic signed [11:0] ofs;
  logic vld, stb;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;
  int k = 0, idx = 0, prev_cfg = 0, e_ofs = 0;
  bit e_stb = 1'b0, e_vld = 1'b0;

  always #4 clk = ~clk;

  ssc_profile_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .range_sel_i(rng), .mode_sel_i(mode),
    .mod_en_i(en), .pd_ni(pd), .offset_o(ofs), .valid_o(vld), .period_stb_o(stb)
  );

  function automatic int unit_of(int r);
    case (r)
      0: return 120;
      1: return 400;
      2: return 200;
      default: return 240;
    endcase
  endfunction

  function automatic int period_of(int r, int i);
    case (i)
      0: return unit_of(r) * 16;
      2: return unit_of(r) * 22;
      default: return unit_of(r) * 19;
    endcase
  endfunction

  function automatic int depth_of(int m);
    case (m)
      0: return 100;
      1: return 300;
      2: return 50;
      default: return 150;
    endcase
  endfunction

  function automatic int tri_val(int m, int p, int kk);
    int d, h, q, w;
    d = depth_of(m);
    h = p / 2;
    q = p / 4;
    if (m >= 2) begin
      w = 2 * d;
      if (kk <= q) return (w * kk) / h;
      if (kk <= 3 * q) return d - (w * (kk - q)) / h;
      return -d + (w * (kk - 3 * q)) / h;
    end
    w = d;
    if (kk <= h) return -((w * kk) / h);
    return -d + (w * (kk - h)) / h;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    int cfg;
    string tag;
    cfg = {28'd0, rng, mode};
    @(posedge clk);
    if (!pd || !en || cfg != prev_cfg) begin
      k = 0; idx = 0; e_stb = 1'b0;
    end else begin
      k++;
      e_stb = 1'b0;
      if (k == period_of(rng, idx)) begin
        k = 0; idx = (idx + 1) % 4; e_stb = 1'b1;
      end
    end
    prev_cfg = cfg;
    e_vld = pd && en;
    e_ofs = e_vld ? tri_val(mode, period_of(rng, idx), k) : 0;
    @(negedge clk);
    if (e_vld) tag = (mode >= 2) ? "R3/R4 center offset" : "R3/R5 down offset";
    else tag = pd ? "R6 offset while disabled" : "R7 offset in power-down";
    check(ofs == e_ofs, tag, ofs, e_ofs);
    check(stb == e_stb, "R8 period strobe", stb, e_stb);
    check(vld == e_vld, "R6/R7 valid flag", vld, e_vld);
  endtask

  task automatic configure(int r, int m);
    en = 1'b0;
    rng = r[1:0];
    mode = m[1:0];
    step();
    step();
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int mx, mn, nstb, r;
    int pos[4];
    void'($urandom(32'd715));
    repeat (3) @(negedge clk);
    // R10: reset state
    check(ofs == 0, "R10 offset in reset", ofs, 0);
    check(vld == 1'b0, "R10 valid in reset", vld, 0);
    check(stb == 1'b0, "R10 strobe in reset", stb, 0);
    rst_n = 1'b1;

    // R1 R2 R4: range 00, 1.5 % center, one group of four periods
    configure(0, 3);
    en = 1'b1;
    mx = -9999; mn = 9999; nstb = 0;
    for (int s = 1; s <= 9120; s++) begin
      step();
      if (ofs > mx) mx = ofs;
      if (ofs < mn) mn = ofs;
      if (stb) begin
        if (nstb < 4) pos[nstb] = s;
        nstb++;
      end
    end
    check(nstb == 4, "R2 strobes in one group", nstb, 4);
    check(pos[0] == 1920, "R1 short period end", pos[0], 1920);
    check(pos[1] == 4200, "R2 nominal period end", pos[1], 4200);
    check(pos[2] == 6840, "R2 long period end", pos[2], 6840);
    check(pos[3] == 9120, "R2 group end", pos[3], 9120);
    check(pos[3] / 4 == 2280, "R2 mean period", pos[3] / 4, 2280);
    check(mx == 150, "R4 center positive peak", mx, 150);
    check(mn == -150, "R4 center negative peak", mn, -150);

    // R5: range 10, 3.0 % down, one short period
    configure(2, 1);
    en = 1'b1;
    mx = -9999; mn = 9999; nstb = 0;
    for (int s = 1; s <= 3200; s++) begin
      step();
      if (ofs > mx) mx = ofs;
      if (ofs < mn) mn = ofs;
      if (stb && nstb == 0) begin pos[0] = s; nstb++; end
    end
    check(mn == -300, "R5 down lowest", mn, -300);
    check(mx == 0, "R5 down highest", mx, 0);
    check(pos[0] == 3200, "R1 range 10 short period", pos[0], 3200);

    // R9: rate change while running
    repeat (500) step();
    mode = 2'd0;
    step();
    check(ofs == 0, "R9 offset after rate change", ofs, 0);
    repeat (300) step();
    rng = 2'd3;
    step();
    check(ofs == 0, "R9 offset after range change", ofs, 0);
    repeat (300) step();

    // R6: enable low, then resume
    en = 1'b0;
    repeat (30) step();
    check(ofs == 0 && vld == 1'b0, "R6 idle while disabled", ofs, 0);
    en = 1'b1;
    repeat (400) step();

    // R7: power-down, then resume
    pd = 1'b0;
    repeat (30) step();
    check(ofs == 0 && vld == 1'b0, "R7 idle in power-down", ofs, 0);
    pd = 1'b1;
    step();
    check(ofs == 0 && vld == 1'b1, "R7 resume at period start", ofs, 0);
    repeat (400) step();

    // random segments
    for (int seg = 0; seg < 24; seg++) begin
      rng = 2'($urandom % 4);
      mode = 2'($urandom % 4);
      if ($urandom % 2 == 0) begin en = 1'b1; pd = 1'b1; end
      for (int s = 0; s < 100 + int'($urandom % 3000); s++) begin
        r = int'($urandom % 1000);
        if (r == 0) en = 1'b0;
        else if (r == 1) pd = 1'b0;
        else if (r >= 985) begin en = 1'b1; pd = 1'b1; end
        step();
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule